// File: doc/BRIEF.md
# Seven-to-one multi-lane pixel serializer

This block turns one 35-bit pixel word per pixel clock into six serial bit streams. Five data lanes each carry a seven-bit group of the word. A sixth lane sends a fixed seven-bit pattern that reproduces the pixel clock at the receiver. The word holds thirty colour bits and five timing bits: horizontal sync, vertical sync, data enable and two spare control bits. Their placement inside the word is left to the integrator, and the block treats every bit the same way. Each lane runs at seven times the pixel rate. A pixel clock of 8 to 135 MHz therefore gives up to 945 Mbit/s per lane.

The word is captured on the rising or the falling pixel-clock edge, as chosen by a select pin. It is then handed to the lane shift registers on the first bit slot of each frame. An outside source provides a seven-times bit clock and a one-cycle frame strobe that marks that first slot. An active-low power-down pin does two things while it is low: it clears all capture and shift state, and it drops a drive-enable flag that stands for high-impedance outputs. After release, one full frame period is spent priming the capture path, so no stale or partial word ever reaches the lanes.

Top module: `disp_serializer`

## Requirements
- R1: At a bit-clock edge that loads a frame, data lane g takes `pix_data[7g+6:7g]`. In the bit-clock cycle right after that edge it sends bit 7g+6. The following cycles send the lower bits in descending order, and bit 7g goes out in the seventh cycle.
- R2: Every frame strobe sampled high while the block is running starts a new frame at once. With a strobe every seven bit cycles, frames follow one another with no idle slot between them.
- R3: In every running frame the clock lane sends 1,1,0,0,0,1,1 in that time order, starting in the cycle after the load edge.
- R4: With `rise_sel` high, the loaded word is the one present at the latest rising pixel-clock edge. With `rise_sel` low, it is the one present at the latest falling edge.
- R5: `drive_en_o` is low after any bit-clock edge that samples `pwrdn_n` low and high after any edge that samples it high (reset low). While `drive_en_o` is low, all six lane outputs are held low.
- R6: After reset or power-down release, the first sampled frame strobe loads nothing. During that priming frame, all data lanes and the clock lane send 0.
- R7: The first frame sent after release is loaded at the second strobe. It carries a word captured at a pixel-clock edge after release, never one from before the power-down.
- R8: While `rst` is high, `drive_en_o` and all lane outputs are low after the next bit-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high reset |
| bit_clk | input | 1 | Serial bit clock, seven times the pixel clock |
| pix_clk | input | 1 | Pixel clock |
| frame_stb | input | 1 | One-cycle strobe on the first bit slot of each frame |
| rise_sel | input | 1 | Capture edge: 1 rising, 0 falling |
| pwrdn_n | input | 1 | Active-low power-down |
| pix_data | input | 35 | Parallel pixel word, seven bits per lane |
| lane_o | output | 5 | Serial data lanes, bit g is lane g |
| lane_clk_o | output | 1 | Serial forwarded-clock lane |
| drive_en_o | output | 1 | Output-enable flag, low stands for high impedance |

## Verification
The assertions assume that the frame strobe arrives exactly every seven bit cycles, and that the pixel and bit clocks are phase-locked, with no pixel-clock edge falling on a load edge. They also assume that the power-down pin changes in step with the bit clock. The bench builds both clocks from one timebase. Its pixel edges sit 42 ns and 14 ns before each load edge, and it changes the strobe, the data and the power-down pin only on falling bit-clock edges. Two different words are driven in each pixel period, one just before each capture edge, so the two capture edges always see different values.

// File: rtl/disp_ser_pkg.sv
package disp_ser_pkg;

    localparam int DS_LANES = 5;
    localparam int DS_SLOTS = 7;

    typedef enum logic [1:0] {
        SEQ_HOLD  = 2'd0,
        SEQ_PRIME = 2'd1,
        SEQ_RUN   = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic clear;
        logic load;
        logic shift;
    } lane_ctl_t;

    // Forwarded-clock frame: high for the leading and trailing slots,
    // low in the middle; for seven slots this gives 1100011 (MSB sent first).
    function automatic logic [31:0] clk_pattern(input int slots);
        logic [31:0] pat;
        int lead;
        pat  = '0;
        lead = slots / 2 - 1;
        for (int p = 0; p < slots; p++) begin
            if (p < lead || p >= slots - lead) begin
                pat[slots-1-p] = 1'b1;
            end
        end
        return pat;
    endfunction

endpackage

// File: rtl/dser_capture.sv
module dser_capture #(
    parameter int WIDTH = 35
) (
    input  logic             pix_clk,
    input  logic             rst,
    input  logic             pwrdn_n,
    input  logic             rise_sel,
    input  logic [WIDTH-1:0] pix_data,
    output logic [WIDTH-1:0] cap_word
);

    logic             hold;
    logic [WIDTH-1:0] rise_q;
    logic [WIDTH-1:0] fall_q;

    assign hold = rst | ~pwrdn_n;

    always_ff @(posedge pix_clk) begin
        if (hold) begin
            rise_q <= '0;
        end else begin
            rise_q <= pix_data;
        end
    end

    always_ff @(negedge pix_clk) begin
        if (hold) begin
            fall_q <= '0;
        end else begin
            fall_q <= pix_data;
        end
    end

    assign cap_word = rise_sel ? rise_q : fall_q;

endmodule

// File: rtl/dser_sequencer.sv
module dser_sequencer
    import disp_ser_pkg::*;
(
    input  logic      bit_clk,
    input  logic      rst,
    input  logic      pwrdn_n,
    input  logic      frame_stb,
    output lane_ctl_t ctl,
    output logic      drive_en_o
);

    seq_state_e st_q;
    seq_state_e st_d;
    logic       off;
    logic       drive_q;

    assign off = rst | ~pwrdn_n;

    always_comb begin
        st_d = st_q;
        case (st_q)
            SEQ_HOLD:  if (frame_stb) st_d = SEQ_PRIME;
            SEQ_PRIME: if (frame_stb) st_d = SEQ_RUN;
            SEQ_RUN:   st_d = SEQ_RUN;
            default:   st_d = SEQ_HOLD;
        endcase
    end

    always_ff @(posedge bit_clk) begin
        if (off) begin
            st_q <= SEQ_HOLD;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge bit_clk) begin
        drive_q <= ~off;
    end

    assign drive_en_o = drive_q;
    assign ctl.clear  = off;
    assign ctl.load   = ~off & frame_stb & (st_q != SEQ_HOLD);
    assign ctl.shift  = ~off & ~frame_stb & (st_q == SEQ_RUN);

endmodule

// File: rtl/dser_lane.sv
module dser_lane
    import disp_ser_pkg::*;
#(
    parameter int SLOTS = 7
) (
    input  logic             bit_clk,
    input  lane_ctl_t        ctl,
    input  logic [SLOTS-1:0] par_i,
    output logic             ser_o
);

    logic [SLOTS-1:0] sh_q;

    always_ff @(posedge bit_clk) begin
        if (ctl.clear) begin
            sh_q <= '0;
        end else if (ctl.load) begin
            sh_q <= par_i;
        end else if (ctl.shift) begin
            sh_q <= {sh_q[SLOTS-2:0], 1'b0};
        end
    end

    assign ser_o = sh_q[SLOTS-1];

endmodule

// File: rtl/disp_serializer.sv
module disp_serializer
    import disp_ser_pkg::*;
#(
    parameter int LANES = DS_LANES,
    parameter int SLOTS = DS_SLOTS
) (
    input  logic                   rst,
    input  logic                   bit_clk,
    input  logic                   pix_clk,
    input  logic                   frame_stb,
    input  logic                   rise_sel,
    input  logic                   pwrdn_n,
    input  logic [LANES*SLOTS-1:0] pix_data,
    output logic [LANES-1:0]       lane_o,
    output logic                   lane_clk_o,
    output logic                   drive_en_o
);

    localparam int               WORD_W  = LANES * SLOTS;
    localparam logic [SLOTS-1:0] CLK_PAT = SLOTS'(clk_pattern(SLOTS));

    logic [WORD_W-1:0] cap_word;
    lane_ctl_t         seq_ctl;
    logic              load_now;

    dser_capture #(.WIDTH(WORD_W)) u_capture (
        .pix_clk  (pix_clk),
        .rst      (rst),
        .pwrdn_n  (pwrdn_n),
        .rise_sel (rise_sel),
        .pix_data (pix_data),
        .cap_word (cap_word)
    );

    dser_sequencer u_seq (
        .bit_clk    (bit_clk),
        .rst        (rst),
        .pwrdn_n    (pwrdn_n),
        .frame_stb  (frame_stb),
        .ctl        (seq_ctl),
        .drive_en_o (drive_en_o)
    );

    assign load_now = seq_ctl.load;

    for (genvar g = 0; g < LANES; g++) begin : g_data_lane
        dser_lane #(.SLOTS(SLOTS)) u_lane (
            .bit_clk (bit_clk),
            .ctl     (seq_ctl),
            .par_i   (cap_word[g*SLOTS +: SLOTS]),
            .ser_o   (lane_o[g])
        );
    end

    dser_lane #(.SLOTS(SLOTS)) u_clk_lane (
        .bit_clk (bit_clk),
        .ctl     (seq_ctl),
        .par_i   (CLK_PAT),
        .ser_o   (lane_clk_o)
    );

endmodule

// File: rtl/dser_checker.sv
module dser_checker
    import disp_ser_pkg::*;
#(
    parameter int LANES = DS_LANES,
    parameter int SLOTS = DS_SLOTS
) (
    input logic                   bit_clk,
    input logic                   rst,
    input logic                   pwrdn_n,
    input logic                   frame_stb,
    input logic                   drive_en_o,
    input logic [LANES-1:0]       lane_o,
    input logic                   lane_clk_o,
    input logic [LANES*SLOTS-1:0] cap_word,
    input logic                   load_now
);

    localparam int               CW  = $clog2(SLOTS + 1);
    localparam logic [SLOTS-1:0] PAT = SLOTS'(clk_pattern(SLOTS));

    logic [CW-1:0]    slot_q;
    logic             seen_q;
    logic             active_q;
    logic [1:0]       stb_since_q;
    logic [LANES-1:0] first_bits;

    for (genvar g = 0; g < LANES; g++) begin : g_first
        assign first_bits[g] = cap_word[g*SLOTS + SLOTS - 1];
    end

    always_ff @(posedge bit_clk) begin
        if (rst) begin
            slot_q <= '0;
            seen_q <= 1'b0;
        end else begin
            if (frame_stb) begin
                slot_q <= '0;
                seen_q <= 1'b1;
            end else if (slot_q < CW'(SLOTS)) begin
                slot_q <= slot_q + 1'b1;
            end
        end
    end

    always_ff @(posedge bit_clk) begin
        if (rst || !pwrdn_n) begin
            active_q    <= 1'b0;
            stb_since_q <= '0;
        end else begin
            if (load_now) active_q <= 1'b1;
            if (frame_stb && stb_since_q != 2'd3) stb_since_q <= stb_since_q + 1'b1;
        end
    end

    AST_ENABLE_DROPS: assert property (@(posedge bit_clk) disable iff (rst)
        !pwrdn_n |=> !drive_en_o); // R5
    AST_ENABLE_RISES: assert property (@(posedge bit_clk) disable iff (rst)
        pwrdn_n |=> drive_en_o); // R5
    AST_QUIET_WHEN_OFF: assert property (@(posedge bit_clk) disable iff (rst)
        !drive_en_o |-> (lane_o == '0 && !lane_clk_o)); // R5
    AST_CLK_LANE_PATTERN: assert property (@(posedge bit_clk) disable iff (rst)
        (active_q && slot_q < CW'(SLOTS)) |-> lane_clk_o == PAT[SLOTS-1-int'(slot_q)]); // R3
    AST_FIRST_BIT_MSB: assert property (@(posedge bit_clk) disable iff (rst)
        (active_q && $past(load_now)) |-> lane_o == $past(first_bits)); // R1
    AST_STROBE_PERIOD: assert property (@(posedge bit_clk) disable iff (rst)
        (seen_q && frame_stb) |-> slot_q == CW'(SLOTS - 1)); // R2
    AST_NO_LOAD_UNPRIMED: assert property (@(posedge bit_clk) disable iff (rst)
        load_now |-> stb_since_q != 2'd0); // R6

endmodule

bind disp_serializer dser_checker #(.LANES(LANES), .SLOTS(SLOTS)) u_chk (
    .bit_clk    (bit_clk),
    .rst        (rst),
    .pwrdn_n    (pwrdn_n),
    .frame_stb  (frame_stb),
    .drive_en_o (drive_en_o),
    .lane_o     (lane_o),
    .lane_clk_o (lane_clk_o),
    .cap_word   (cap_word),
    .load_now   (load_now)
);

// File: tb/disp_serializer_tb.sv
module disp_serializer_tb;

    localparam int L     = 5;
    localparam int S     = 7;
    localparam int W     = L * S;
    localparam int M_END = 1900;
    localparam logic [6:0] CLK_FRAME = 7'b1100011;

    logic         bit_clk   = 1'b0;
    logic         pix_clk   = 1'b0;
    logic         rst       = 1'b1;
    logic         frame_stb = 1'b0;
    logic         rise_sel  = 1'b1;
    logic         pwrdn_n   = 1'b1;
    logic [W-1:0] pix_data  = '0;
    logic [L-1:0] lane_o;
    logic         lane_clk_o;
    logic         drive_en_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // bench reference state, built from the requirements
    logic [W-1:0] m_rise = '0;
    logic [W-1:0] m_fall = '0;
    logic [W-1:0] m_word = '0;
    int           m_st   = 0;   // 0 hold, 1 primed, 2 sending
    int           m_slot = 0;
    logic         m_oe   = 1'b0;
    bit           m_first = 1'b0;
    bit           m_sel   = 1'b1;

    disp_serializer u_dut (
        .rst        (rst),
        .bit_clk    (bit_clk),
        .pix_clk    (pix_clk),
        .frame_stb  (frame_stb),
        .rise_sel   (rise_sel),
        .pwrdn_n    (pwrdn_n),
        .pix_data   (pix_data),
        .lane_o     (lane_o),
        .lane_clk_o (lane_clk_o),
        .drive_en_o (drive_en_o)
    );

    always #4 bit_clk = ~bit_clk;   // 125 MHz

    initial begin
        #2;
        forever begin
            pix_clk = 1'b1;
            #28;
            pix_clk = 1'b0;
            #28;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] rnd_word();
        return W'({$urandom, $urandom});
    endfunction

    function automatic logic [W-1:0] directed_word(input int idx);
        logic [W-1:0] w;
        w = '0;
        case (idx % 4)
            0: w = '1;
            1: for (int b = 0; b < W; b += 2) w[b] = 1'b1;
            2: for (int g = 0; g < L; g++) w[g*S + (g % S)] = 1'b1;
            default: w = '0;
        endcase
        return w;
    endfunction

    task automatic model_bit_edge();
        if (rst || !pwrdn_n) begin
            m_oe = 1'b0;
            m_st = 0;
        end else begin
            m_oe = 1'b1;
            if (frame_stb) begin
                if (m_st == 0) begin
                    m_st = 1;
                end else begin
                    m_word  = rise_sel ? m_rise : m_fall;
                    m_sel   = rise_sel;
                    m_first = (m_st == 1);
                    m_slot  = 0;
                    m_st    = 2;
                end
            end else if (m_st == 2 && m_slot < S - 1) begin
                m_slot++;
            end
        end
    endtask

    task automatic check_outputs();
        logic [L-1:0] exp_l;
        if (rst) begin
            chk("R8 enable in reset", 64'(drive_en_o), 64'(0));
            chk("R8 lanes in reset", 64'({lane_clk_o, lane_o}), 64'(0));
        end else begin
            chk("R5 drive enable", 64'(drive_en_o), 64'(m_oe));
            if (m_oe) begin
                if (m_st != 2) begin
                    chk("R6 priming frame idle", 64'({lane_clk_o, lane_o}), 64'(0));
                end else begin
                    for (int g = 0; g < L; g++) exp_l[g] = m_word[g*S + S - 1 - m_slot];
                    if (m_first)          chk("R7 first word after release", 64'(lane_o), 64'(exp_l));
                    else if (m_slot == 0) chk("R2 frame start bit", 64'(lane_o), 64'(exp_l));
                    else if (!m_sel)      chk("R4 falling-edge capture", 64'(lane_o), 64'(exp_l));
                    else                  chk("R1 lane bit order", 64'(lane_o), 64'(exp_l));
                    chk("R3 clock lane", 64'(lane_clk_o), 64'(CLK_FRAME[S-1-m_slot]));
                end
            end
        end
    endtask

    task automatic drive_inputs(input int m);
        bit directed;
        rst       = (m < 20) || (m >= 1700 && m < 1712);
        pwrdn_n   = !((m >= 600 && m < 650) || (m >= 900 && m < 943) || m == 1200);
        rise_sel  = !((m >= 300 && m < 600) || (m >= 1300 && m < 1400));
        frame_stb = (m % 7 == 5);
        directed  = (m >= 1400 && m < 1500);
        if (m % 7 == 2) pix_data = directed ? directed_word(m / 7) : rnd_word();
        if (m % 7 == 6) pix_data = directed ? directed_word(m / 7) : rnd_word();
    endtask

    initial begin
        int seed_v;
        seed_v = $urandom(32'h5EED_0C3A);
        n_run = n_run + 0 * seed_v;
        for (int m = 1; m <= M_END; m++) begin
            @(negedge bit_clk);
            if (m % 7 == 1) m_rise = (rst || !pwrdn_n) ? '0 : pix_data;
            model_bit_edge();
            if (m % 7 == 4) m_fall = (rst || !pwrdn_n) ? '0 : pix_data;
            check_outputs();
            drive_inputs(m);
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule